// File: doc/BRIEF.md
# Predicated Data-Processing Execute Unit

This block carries out one register-to-register data-processing instruction on a 32-bit word. Each cycle it takes the instruction word, the values already read for the first operand register and the second operand register, and the current four-bit flag vector (negative, zero, carry, overflow). It decides from the 4-bit predicate field whether the instruction takes effect. It builds the second operand from either a rotated 8-bit constant or a shifted register value, and runs one of sixteen ALU operations. It returns the result, the destination index with a write strobe, and the flag vector to keep.

Register reads and write-back stay outside the block. The surrounding pipeline hands in operand values and retires the result. With the `OUT_REG` parameter at 1 (the default), the outputs are registered and appear one clock after the inputs. At 0 the path is purely combinational.

Top module: `dp_exec_unit`

## Requirements
- R1: While `rst_n` is low (with `OUT_REG`=1), the outputs are held at zero: `rd_we_o`=0, `flags_o`=0 and `result_o`=0.
- R2: The predicate in `instr_i[31:28]` is decoded against flags (bit 3 N, bit 2 Z, bit 1 C, bit 0 V):
  - 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V.
  - 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
  - 14 always; 15 never.
- R3: When the predicate fails, `rd_we_o` is 0 and `flags_o` equals `flags_i`.
- R4: When `instr_i[25]`=1, the second operand is `instr_i[7:0]` rotated right by 2×`instr_i[11:8]`. The shifter carry is the current C for a rotation of 0, and bit 31 of the operand otherwise.
- R5: When `instr_i[25]`=0, the second operand is `rm_val_i` shifted by `instr_i[11:7]` (1..31) with the kind set by `instr_i[6:5]`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The shifter carry is the last bit shifted out (for rotate, the result's bit 31).
- R6: A register shift amount of 0 passes `rm_val_i` through unchanged and gives a shifter carry equal to the current C.
- R7: `instr_i[24:21]` selects the operation: 0 and, 1 eor, 2 sub, 3 rsb, 4 add, 5 adc, 6 sbc (a-b+C-1), 7 rsc (b-a+C-1), 8 tst, 9 teq, 10 cmp, 11 cmn, 12 orr, 13 mov, 14 bic (a&~b), 15 mvn (~b). An executed operation other than 8..11 raises `rd_we_o`, gives the value on `result_o` and gives `instr_i[15:12]` on `rd_idx_o`.
- R8: Operations 8..11 never raise `rd_we_o`, and when executed they update the flags even with `instr_i[20]`=0.
- R9: An executed teq leaves C equal to its incoming value.
- R10: For and, eor, tst, orr, mov, bic and mvn with flags updated: N is result bit 31, Z is result==0, C is the shifter carry and V is kept.
- R11: For the arithmetic operations with flags updated: C is the unsigned carry out (1 means no borrow for subtraction), V is the signed 32-bit overflow, and N and Z follow the result.
- R12: An executed operation 0..7 or 12..15 with `instr_i[20]`=0 leaves `flags_o` equal to `flags_i`.
- R13: An instruction whose `instr_i[27:26]` is not 00 has no effect: `rd_we_o`=0 and `flags_o`=`flags_i`.
- R14: With `OUT_REG`=1, outputs for the inputs present at a rising clock edge appear after that edge and stay stable until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rn_val_i | input | 32 | Value of the first operand register |
| rm_val_i | input | 32 | Value of the second operand register |
| flags_i | input | 4 | Current flags N,Z,C,V (bit 3 down to bit 0) |
| result_o | output | 32 | ALU result |
| rd_we_o | output | 1 | Destination write strobe |
| rd_idx_o | output | 4 | Destination register index |
| flags_o | output | 4 | Flags to retain after this instruction |

## Verification
The bench pairs every predicate code with all sixteen flag vectors. A design that swaps a signed predicate would write on the wrong sign relation. One that treats code 15 as always would corrupt registers. Every operation is swept across operand values at the signed and unsigned edges, with carry in set and clear, so that these faults show up:
- a borrow given with the wrong polarity;
- a missing carry in for sbc and rsc;
- teq clobbering C;
- a compare that writes its destination.

Shift amounts 0 through 31 of each kind are swept, along with all sixteen immediate rotations. An off-by-one in the carry tap, or a zero amount that shifts by 32, would give wrong operands or carries.

// File: rtl/dp_exec_pkg.sv
// Shared encodings for the data-processing execute unit.
// Assumes 32-bit instruction words; the field positions are fixed by the encoding.
package dp_exec_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
    } shift_kind_e;

    // Flag vector bit positions
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

endpackage

// File: rtl/dpx_cond_eval.sv
// Predicate evaluator: decides from the 4-bit predicate and the flags
// whether the instruction takes effect. Purely combinational.
module dpx_cond_eval
    import dp_exec_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);
    logic n, z, c, v;
    assign n = flags_i[FLG_N];
    assign z = flags_i[FLG_Z];
    assign c = flags_i[FLG_C];
    assign v = flags_i[FLG_V];

    // Pick the predicate outcome for each code
    always_comb begin
        unique case (cond_i)
            4'd0:    pass_o = z;
            4'd1:    pass_o = !z;
            4'd2:    pass_o = c;
            4'd3:    pass_o = !c;
            4'd4:    pass_o = n;
            4'd5:    pass_o = !n;
            4'd6:    pass_o = v;
            4'd7:    pass_o = !v;
            4'd8:    pass_o = c && !z;
            4'd9:    pass_o = !c || z;
            4'd10:   pass_o = (n == v);
            4'd11:   pass_o = (n != v);
            4'd12:   pass_o = !z && (n == v);
            4'd13:   pass_o = z || (n != v);
            4'd14:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpx_operand.sv
// Second-operand former: a rotated 8-bit constant or a shifted register value,
// with the shifter carry. The shift amount comes from the instruction only;
// bit 4 (register-held amount) is out of scope and not decoded.
module dpx_operand
    import dp_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic                  use_imm_i,
    input  logic [3:0]            rot_i,
    input  logic [IMM_W-1:0]      imm_i,
    input  logic [1:0]            kind_i,
    input  logic [$clog2(DATA_W)-1:0] amt_i,
    input  logic [DATA_W-1:0]     rm_i,
    input  logic                  c_i,
    output logic [DATA_W-1:0]     op2_o,
    output logic                  carry_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     rot_amt;
    logic [DATA_W-1:0]   imm_ext;
    logic [2*DATA_W-1:0] imm_dbl;
    logic [DATA_W-1:0]   imm_val;
    logic [SH_W-1:0]     amt_m1;
    logic [DATA_W-1:0]   lsl_pre, lsr_pre, asr_pre;
    logic [2*DATA_W-1:0] ror_dbl;
    logic [DATA_W-1:0]   reg_val;
    logic                reg_carry;

    // Constant path: rotate the zero-extended byte right by twice the field
    always_comb begin
        rot_amt = SH_W'({rot_i, 1'b0});
        imm_ext = DATA_W'(imm_i);
        imm_dbl = {imm_ext, imm_ext} >> rot_amt;
        imm_val = imm_dbl[DATA_W-1:0];
    end

    // Register path: shift by amount-1 first so the carry bit sits at an end
    always_comb begin
        amt_m1  = amt_i - 1'b1;
        lsl_pre = rm_i << amt_m1;
        lsr_pre = rm_i >> amt_m1;
        asr_pre = DATA_W'($signed(rm_i) >>> amt_m1);
        ror_dbl = {rm_i, rm_i} >> amt_i;
        if (amt_i == '0) begin
            reg_val   = rm_i;
            reg_carry = c_i;
        end else begin
            unique case (shift_kind_e'(kind_i))
                SH_LSL: begin
                    reg_val   = lsl_pre << 1;
                    reg_carry = lsl_pre[DATA_W-1];
                end
                SH_LSR: begin
                    reg_val   = lsr_pre >> 1;
                    reg_carry = lsr_pre[0];
                end
                SH_ASR: begin
                    reg_val   = {asr_pre[DATA_W-1], asr_pre[DATA_W-1:1]};
                    reg_carry = asr_pre[0];
                end
                default: begin
                    reg_val   = ror_dbl[DATA_W-1:0];
                    reg_carry = ror_dbl[DATA_W-1];
                end
            endcase
        end
    end

    // Select the operand source and its carry
    always_comb begin
        if (use_imm_i) begin
            op2_o   = imm_val;
            carry_o = (rot_i == 4'd0) ? c_i : imm_val[DATA_W-1];
        end else begin
            op2_o   = reg_val;
            carry_o = reg_carry;
        end
    end
endmodule

// File: rtl/dpx_alu.sv
// Sixteen-operation ALU with flag generation. Arithmetic uses a single adder
// fed with optionally inverted operands and a selected carry in.
module dpx_alu
    import dp_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [3:0]        flags_i,
    input  logic              sh_carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic [3:0]        flags_o,
    output logic              writes_rd_o,
    output logic              compare_o
);
    logic [DATA_W-1:0] add_x, add_y;
    logic              add_cin;
    logic [DATA_W:0]   sum;
    logic              arith;
    logic [DATA_W-1:0] logic_res;
    logic              c_in;

    assign c_in = flags_i[FLG_C];

    // Choose adder inputs for the arithmetic operations
    always_comb begin
        add_x   = a_i;
        add_y   = b_i;
        add_cin = 1'b0;
        arith   = 1'b1;
        unique case (alu_op_e'(op_i))
            OP_SUB, OP_CMP: begin add_y = ~b_i; add_cin = 1'b1; end
            OP_RSB:         begin add_x = b_i; add_y = ~a_i; add_cin = 1'b1; end
            OP_ADD, OP_CMN: begin add_cin = 1'b0; end
            OP_ADC:         begin add_cin = c_in; end
            OP_SBC:         begin add_y = ~b_i; add_cin = c_in; end
            OP_RSC:         begin add_x = b_i; add_y = ~a_i; add_cin = c_in; end
            default:        arith = 1'b0;
        endcase
    end

    // Single carry-propagate adder
    assign sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};

    // Bitwise operations
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND, OP_TST: logic_res = a_i & b_i;
            OP_EOR, OP_TEQ: logic_res = a_i ^ b_i;
            OP_ORR:         logic_res = a_i | b_i;
            OP_MOV:         logic_res = b_i;
            OP_BIC:         logic_res = a_i & ~b_i;
            default:        logic_res = ~b_i;
        endcase
    end

    // Result and flag formation
    always_comb begin
        res_o = arith ? sum[DATA_W-1:0] : logic_res;
        flags_o[FLG_N] = res_o[DATA_W-1];
        flags_o[FLG_Z] = (res_o == '0);
        if (arith) begin
            flags_o[FLG_C] = sum[DATA_W];
            flags_o[FLG_V] = (add_x[DATA_W-1] == add_y[DATA_W-1]) &&
                             (sum[DATA_W-1] != add_x[DATA_W-1]);
        end else begin
            flags_o[FLG_C] = (alu_op_e'(op_i) == OP_TEQ) ? c_in : sh_carry_i;
            flags_o[FLG_V] = flags_i[FLG_V];
        end
    end

    // Compare-class operations discard the result and always set flags
    assign compare_o   = (op_i[3:2] == 2'b10);
    assign writes_rd_o = !compare_o;
endmodule

// File: rtl/dp_exec_unit.sv
// Top of the predicated data-processing execute unit. Decodes the fields,
// evaluates the predicate, forms operand 2, runs the ALU and, if OUT_REG is 1,
// registers the outputs. Assumes operand values arrive already read.
module dp_exec_unit
    import dp_exec_pkg::*;
#(
    parameter int  DATA_W  = 32,
    parameter bit  OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rn_val_i,
    input  logic [DATA_W-1:0] rm_val_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              rd_we_o,
    output logic [3:0]        rd_idx_o,
    output logic [3:0]        flags_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic              cond_ok, is_dp, exec;
    logic [DATA_W-1:0] op2, alu_res;
    logic              sh_carry, writes_rd, compare;
    logic [3:0]        alu_flags;
    logic [DATA_W-1:0] res_n;
    logic              we_n;
    logic [3:0]        flags_n;
    logic              unused_fields;

    // Register numbers of the operands and the register-amount bit are not used here
    assign unused_fields = ^{instr_i[19:16], instr_i[4], instr_i[3:0]};

    dpx_cond_eval u_cond (
        .cond_i  (instr_i[31:28]),
        .flags_i (flags_i),
        .pass_o  (cond_ok)
    );

    dpx_operand #(.DATA_W(DATA_W), .IMM_W(8)) u_opnd (
        .use_imm_i (instr_i[25]),
        .rot_i     (instr_i[11:8]),
        .imm_i     (instr_i[7:0]),
        .kind_i    (instr_i[6:5]),
        .amt_i     (instr_i[7+SH_W-1:7]),
        .rm_i      (rm_val_i),
        .c_i       (flags_i[FLG_C]),
        .op2_o     (op2),
        .carry_o   (sh_carry)
    );

    dpx_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i        (instr_i[24:21]),
        .a_i         (rn_val_i),
        .b_i         (op2),
        .flags_i     (flags_i),
        .sh_carry_i  (sh_carry),
        .res_o       (alu_res),
        .flags_o     (alu_flags),
        .writes_rd_o (writes_rd),
        .compare_o   (compare)
    );

    // Gate write and flag update by instruction class and predicate
    always_comb begin
        is_dp   = (instr_i[27:26] == 2'b00);
        exec    = is_dp && cond_ok;
        we_n    = exec && writes_rd;
        flags_n = (exec && (instr_i[20] || compare)) ? alu_flags : flags_i;
        res_n   = alu_res;
    end

    generate
        if (OUT_REG) begin : g_reg
            // Output register with synchronous active-low reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result_o <= '0;
                    rd_we_o  <= 1'b0;
                    rd_idx_o <= '0;
                    flags_o  <= '0;
                end else begin
                    result_o <= res_n;
                    rd_we_o  <= we_n;
                    rd_idx_o <= instr_i[15:12];
                    flags_o  <= flags_n;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign result_o = res_n;
            assign rd_we_o  = we_n;
            assign rd_idx_o = instr_i[15:12];
            assign flags_o  = flags_n;
        end
    endgenerate
endmodule

// File: rtl/dp_exec_chk.sv
// Property checker for dp_exec_unit, attached by bind. Holds a copy of the
// inputs aligned with the output latency and checks outputs against them.
module dp_exec_chk #(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              rd_we_o,
    input logic [3:0]        flags_o
);
    logic [31:0] ins_s;
    logic [3:0]  flg_s;
    logic        live_s;
    logic        unused_bits;

    generate
        if (OUT_REG) begin : g_lat
            // Align input copy with the registered outputs
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ins_s  <= '0;
                    flg_s  <= '0;
                    live_s <= 1'b0;
                end else begin
                    ins_s  <= instr_i;
                    flg_s  <= flags_i;
                    live_s <= 1'b1;
                end
            end
        end else begin : g_now
            assign ins_s  = instr_i;
            assign flg_s  = flags_i;
            assign live_s = 1'b1;
        end
    endgenerate

    assign unused_bits = ^{ins_s[19:0]};

    logic cls_dp, is_cmp, is_logic;
    assign cls_dp   = (ins_s[27:26] == 2'b00);
    assign is_cmp   = (ins_s[24:23] == 2'b10);
    assign is_logic = (ins_s[24:21] == 4'd0) || (ins_s[24:21] == 4'd1) ||
                      (ins_s[24:21] == 4'd8) || (ins_s[24:21] >= 4'd12);

    assert_never_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && ins_s[31:28] == 4'hF) |-> (!rd_we_o && flags_o == flg_s));

    assert_compare_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && is_cmp) |-> !rd_we_o);

    assert_teq_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && ins_s[24:21] == 4'd9) |-> (flags_o[1] == flg_s[1]));

    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && !ins_s[20] && !is_cmp) |-> (flags_o == flg_s));

    assert_class_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && !cls_dp) |-> (!rd_we_o && flags_o == flg_s));

    assert_logic_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_s && rd_we_o && ins_s[20] && is_logic) |->
        (flags_o[3] == result_o[DATA_W-1] && flags_o[2] == (result_o == '0) &&
         flags_o[0] == flg_s[0]));
endmodule

bind dp_exec_unit dp_exec_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_i  (instr_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .rd_we_o  (rd_we_o),
    .flags_o  (flags_o)
);

// File: tb/dp_exec_unit_tb_top.sv
// Sweep bench for dp_exec_unit with the registered output (default parameters).
module dp_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rn_val = '0;
    logic [31:0] rm_val = '0;
    logic [3:0]  flags = '0;
    logic [31:0] res;
    logic        we;
    logic [3:0]  rd;
    logic [3:0]  fo;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dp_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rn_val_i(rn_val),
        .rm_val_i(rm_val), .flags_i(flags), .result_o(res), .rd_we_o(we),
        .rd_idx_o(rd), .flags_o(fo)
    );

    function automatic logic [31:0] pat(int i);
        case (i % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hA5A5_F00F;
            default: return 32'h0000_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] mk(logic [3:0] cnd, logic [1:0] cls, logic im,
                                       logic [3:0] op, logic s, logic [3:0] rdx,
                                       logic [11:0] o2);
        return {cnd, cls, im, op, s, 4'd3, rdx, o2};
    endfunction

    // Reference model built from the requirement text
    task automatic ref_model(input logic [31:0] ins, input logic [31:0] a, b,
                             input logic [3:0] f, output logic [31:0] r,
                             output logic w, output logic [3:0] fn);
        logic n, z, c, v, ok, sc, upd;
        logic [31:0] val;
        logic [3:0] op;
        longint u, sg, ua, ub, sa, sb;
        bit arith, addlike;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (ins[31:28])
            0: ok = z;   1: ok = !z;  2: ok = c;   3: ok = !c;
            4: ok = n;   5: ok = !n;  6: ok = v;   7: ok = !v;
            8: ok = c & !z;  9: ok = !c | z;  10: ok = (n == v); 11: ok = (n != v);
            12: ok = !z & (n == v); 13: ok = z | (n != v); 14: ok = 1; default: ok = 0;
        endcase
        if (ins[25]) begin
            val = {24'd0, ins[7:0]};
            for (int k = 0; k < 2 * ins[11:8]; k++) val = {val[0], val[31:1]};
            sc = (ins[11:8] == 0) ? c : val[31];
        end else begin
            val = b; sc = c;
            for (int k = 0; k < ins[11:7]; k++) begin
                case (ins[6:5])
                    0: begin sc = val[31]; val = val << 1; end
                    1: begin sc = val[0];  val = val >> 1; end
                    2: begin sc = val[0];  val = {val[31], val[31:1]}; end
                    default: begin sc = val[0]; val = {val[0], val[31:1]}; end
                endcase
            end
        end
        op = ins[24:21];
        ua = longint'(a); ub = longint'(val);
        sa = longint'($signed(a)); sb = longint'($signed(val));
        arith = 1; addlike = 0; u = 0; sg = 0;
        case (op)
            2, 10: begin u = ua - ub; sg = sa - sb; end
            3:  begin u = ub - ua; sg = sb - sa; end
            4, 11: begin u = ua + ub; sg = sa + sb; addlike = 1; end
            5:  begin u = ua + ub + c; sg = sa + sb + c; addlike = 1; end
            6:  begin u = ua - ub - (1 - c); sg = sa - sb - (1 - c); end
            7:  begin u = ub - ua - (1 - c); sg = sb - sa - (1 - c); end
            default: arith = 0;
        endcase
        if (arith) begin
            r = u[31:0];
            fn[1] = addlike ? (u >= 64'sh1_0000_0000) : (u >= 0);
            fn[0] = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
        end else begin
            case (op)
                0, 8: r = a & val;  1, 9: r = a ^ val;  12: r = a | val;
                13: r = val;        14: r = a & ~val;    default: r = ~val;
            endcase
            fn[1] = (op == 9) ? c : sc;
            fn[0] = v;
        end
        fn[3] = r[31]; fn[2] = (r == 0);
        upd = ins[20] || (op >= 8 && op <= 11);
        if (ins[27:26] != 2'b00 || !ok) begin
            w = 0; fn = f;
        end else begin
            w = !(op >= 8 && op <= 11);
            if (!upd) fn = f;
        end
    endtask

    task automatic run(input string tag, input logic [31:0] ins, a, b, input logic [3:0] f);
        logic [31:0] er; logic ew; logic [3:0] ef; bit ok;
        instr = ins; rn_val = a; rm_val = b; flags = f;
        ref_model(ins, a, b, f, er, ew, ef);
        @(posedge clk); #1;
        ok = (we === ew) && (fo === ef) && (!ew || (res === er && rd === ins[15:12]));
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s instr=%h a=%h b=%h f=%h: got we=%b res=%h rd=%h flags=%h, expected we=%b res=%h rd=%h flags=%h",
                     tag, ins, a, b, f, we, res, rd, fo, ew, er, ins[15:12], ef);
        end
    endtask

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        instr = mk(4'hE, 2'b00, 1'b1, 4'd13, 1'b1, 4'd7, 12'h0FF);
        flags = 4'hF; rm_val = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", (we === 1'b0) && (fo === 4'h0) && (res === 32'h0),
            {27'd0, we, fo, res}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R3: each predicate against every flag vector
        for (int cc = 0; cc < 16; cc++)
            for (int fv = 0; fv < 16; fv++) begin
                run("R2_R3", mk(cc[3:0], 2'b00, 1'b1, 4'd13, 1'b0, 4'd5, 12'h001), 0, 0, fv[3:0]);
                run("R2_R3", mk(cc[3:0], 2'b00, 1'b1, 4'd13, 1'b1, 4'd6, 12'h000), 0, 0, fv[3:0]);
            end

        // R7 R8 R9 R10 R11 R12: all operations over edge operands
        for (int op = 0; op < 16; op++)
            for (int s = 0; s < 2; s++)
                for (int ia = 0; ia < 8; ia++)
                    for (int ib = 0; ib < 8; ib++)
                        for (int fi = 0; fi < 4; fi++) begin
                            string tg;
                            if (op >= 8 && op <= 11) tg = (op == 9) ? "R8_R9" : "R8";
                            else if (s == 0) tg = "R7_R12";
                            else if ((op >= 2 && op <= 7)) tg = "R7_R11";
                            else tg = "R7_R10";
                            run(tg, mk(4'hE, 2'b00, 1'b0, op[3:0], s[0], ib[3:0], 12'h002),
                                pat(ia), pat(ib + 3), 4'(fi * 5));
                        end

        // R4: every rotation of a few constants, carry in clear and set
        for (int rt = 0; rt < 16; rt++)
            for (int ii = 0; ii < 4; ii++)
                for (int cv = 0; cv < 2; cv++) begin
                    logic [7:0] k8;
                    k8 = (ii == 0) ? 8'h01 : (ii == 1) ? 8'h80 : (ii == 2) ? 8'hFF : 8'hA5;
                    run("R4", mk(4'hE, 2'b00, 1'b1, 4'd13, 1'b1, 4'd2, {rt[3:0], k8}),
                        0, 0, {2'b00, cv[0], 1'b1});
                    run("R4", mk(4'hE, 2'b00, 1'b1, 4'd12, 1'b1, 4'd2, {rt[3:0], k8}),
                        32'h0F00_0010, 0, {2'b00, cv[0], 1'b0});
                end

        // R5 / R6: every shift kind and amount
        for (int kd = 0; kd < 4; kd++)
            for (int am = 0; am < 32; am++)
                for (int iv = 0; iv < 8; iv++)
                    for (int cv = 0; cv < 2; cv++)
                        run((am == 0) ? "R6" : "R5",
                            mk(4'hE, 2'b00, 1'b0, 4'd13, 1'b1, 4'd9,
                               {am[4:0], kd[1:0], 1'b0, 4'd1}),
                            0, pat(iv), {2'b01, cv[0], 1'b0});

        // R13: other instruction classes have no effect
        for (int cl = 1; cl < 4; cl++)
            for (int op = 0; op < 16; op++)
                run("R13", mk(4'hE, cl[1:0], 1'b0, op[3:0], 1'b1, 4'd4, 12'h000),
                    pat(op), pat(op + 1), 4'(op));

        // R14: output follows the edge and is stable between edges
        run("R14", mk(4'hE, 2'b00, 1'b1, 4'd13, 1'b0, 4'd11, 12'h033), 0, 0, 4'h0);
        instr = mk(4'hE, 2'b00, 1'b1, 4'd13, 1'b0, 4'd12, 12'h044);
        #5;
        chk("R14", (res === 32'h33) && (rd === 4'd11), {28'd0, rd, res}, {28'd0, 4'd11, 32'h33});
        @(posedge clk); #1;
        chk("R14", (res === 32'h44) && (rd === 4'd12), {28'd0, rd, res}, {28'd0, 4'd12, 32'h44});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule